// File: doc/BRIEF.md
# Expansion Card Port and Memory Window Decoder

This block sits between a 20-bit, 8-bit-data host bus and the function blocks of a disk-interface expansion card. It recognises three kinds of access. Accesses to a 16-port block of I/O space select the drive register latches. Reads from the lower part of an 8 KB memory window select an option ROM. Reads and writes to the top part of that window select a small scratch RAM.

Two 4-bit switch banks position the windows. The I/O switch picks one of 16 port blocks, each 16 ports long, inside the free I/O area of the target machine. The memory switch picks one of 16 window positions, aligned to 8 KB, between 0xC0000 and 0xDFFFF. Switch values are captured while reset is held and stay frozen afterwards. All select outputs are combinational from the bus address, the strobes and the captured switches.

The drive register index has the lowest and fourth-lowest address bits exchanged, so the latch wiring appears as consecutive ports. ROM and RAM offsets are passed through unaltered, so a plain ROM image can be programmed as it is. A port block that overlaps another onboard device is decoded like any other setting, and nothing blocks it.

Top module: `xcd_top`

## Requirements
- R1: The switch inputs are loaded into a register on every clock edge while `rst` is high, and only then. Switch changes made after reset is released do not move either window.
- R2: For I/O switch value s, the port block base is 0x220 + 16·s when s is 0 to 7, and 0x300 + 16·(s−8) when s is 8 to 15. `drv_cs` is high when address bits 19:4 equal base bits 19:4 and `io_rd` or `io_wr` is high.
- R3: `drv_cs` stays low when only `mem_rd` or `mem_wr` is active, even at an address inside the selected port block.
- R4: `drv_idx` bit 3 = address bit 0, bit 2 = address bit 2, bit 1 = address bit 1, bit 0 = address bit 3. It reads 0 whenever `drv_cs` is low.
- R5: For memory switch value m, the window covers 0xC0000 + 0x2000·m up to 0xC0000 + 0x2000·m + 0x1FFF.
- R6: The RAM covers the top 2^RAM_AW bytes of the window, where window offset bits 12:RAM_AW are all ones. With the default RAM_AW = 10 that is offsets 0x1C00–0x1FFF. `ram_cs` is high there on `mem_rd` or `mem_wr`, and `ram_off` = address bits RAM_AW−1:0.
- R7: `rom_cs` is high only on `mem_rd` within the window below the RAM. `rom_off` equals address bits 12:0 unmodified. `rom_off` and `ram_off` read 0 while their select is low.
- R8: No select is asserted for an address outside the selected port block or memory window, or for a memory address accessed with an I/O strobe.
- R9: At most one of `drv_cs`, `rom_cs` and `ram_cs` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the switch capture register |
| rst | input | 1 | Synchronous active-high reset; switches are captured while high |
| bus_addr | input | 20 | Host bus address |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| io_base_sw | input | 4 | Port block selection switches |
| mem_win_sw | input | 4 | Memory window selection switches |
| drv_cs | output | 1 | Drive register latch select |
| drv_idx | output | 4 | Drive register index, address bits 0 and 3 exchanged |
| rom_cs | output | 1 | Option ROM select |
| rom_off | output | 13 | ROM byte offset within the window |
| ram_cs | output | 1 | Scratch RAM select |
| ram_off | output | RAM_AW (10) | RAM byte offset |

## Verification
Two copies of the decoder are built side by side from the same stimulus. One uses RAM_AW = 10 (1 KB) and the other uses RAM_AW = 9 (512 bytes). This makes the moving ROM/RAM boundary observable: offset 0x1D00 is RAM in one copy and ROM in the other. The default port-block constants are kept, and every one of the 16 port settings and 16 window settings is swept, including the accesses just outside the ends of each range.

// File: rtl/xcd_pkg.sv
`timescale 1ns/1ps
package xcd_pkg;
  localparam int ADDR_W    = 20;
  localparam int SW_W      = 4;
  localparam int IDX_W     = 4;
  localparam int WIN_AW    = 13;
  localparam int POSITIONS = 1 << SW_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SW_W-1:0]   sw_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // Exchange of bit 0 and bit 3 of the port offset.
  function automatic idx_t swap_idx(input idx_t a);
    return {a[0], a[2], a[1], a[3]};
  endfunction
endpackage

// File: rtl/xcd_sw_latch.sv
`timescale 1ns/1ps
module xcd_sw_latch
  import xcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sw_t  io_sw_in,
  input  sw_t  mem_sw_in,
  output sw_t  io_sw_q,
  output sw_t  mem_sw_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      io_sw_q  <= io_sw_in;
      mem_sw_q <= mem_sw_in;
    end
  end

  // R1: once out of reset the captured settings never move
  a_r1_hold_after_release: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) == 1'b0) |-> ($stable(io_sw_q) && $stable(mem_sw_q)));
endmodule

// File: rtl/xcd_io_decode.sv
`timescale 1ns/1ps
module xcd_io_decode
  import xcd_pkg::*;
#(
  parameter int IO_LO_BASE = 'h220,
  parameter int IO_HI_BASE = 'h300,
  parameter int IO_STEP    = 'h10
) (
  input  logic  clk,
  input  logic  rst,
  input  addr_t addr,
  input  logic  io_rd,
  input  logic  io_wr,
  input  sw_t   sw,
  output logic  drv_cs,
  output idx_t  drv_idx
);
  localparam int HALF = POSITIONS / 2;

  logic [POSITIONS-1:0] hit;

  for (genvar i = 0; i < POSITIONS; i++) begin : g_base
    localparam int    BASE_I = (i < HALF) ? IO_LO_BASE + i * IO_STEP
                                          : IO_HI_BASE + (i - HALF) * IO_STEP;
    localparam addr_t BASE_V = BASE_I[ADDR_W-1:0];
    assign hit[i] = (addr[ADDR_W-1:IDX_W] == BASE_V[ADDR_W-1:IDX_W]);
  end

  logic block_hit;
  assign block_hit = hit[sw];
  assign drv_cs    = block_hit & (io_rd | io_wr);
  assign drv_idx   = drv_cs ? swap_idx(addr[IDX_W-1:0]) : '0;

  // R3: memory strobes alone never reach the drive latches
  a_r3_io_strobe_only: assert property (@(posedge clk) disable iff (rst)
    drv_cs |-> (io_rd || io_wr));
  // R4: index is quiet when nothing is selected
  a_r4_idle_index: assert property (@(posedge clk) disable iff (rst)
    !drv_cs |-> (drv_idx == '0));
  // R2: every selectable block lies inside the low 1 KB of port space
  a_r2_port_span: assert property (@(posedge clk) disable iff (rst)
    drv_cs |-> (addr[ADDR_W-1:10] == '0));
endmodule

// File: rtl/xcd_mem_decode.sv
`timescale 1ns/1ps
module xcd_mem_decode
  import xcd_pkg::*;
#(
  parameter int WIN_BASE = 'hC0000,
  parameter int RAM_AW   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_t             addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  sw_t               sw,
  output logic              rom_cs,
  output logic [WIN_AW-1:0] rom_off,
  output logic              ram_cs,
  output logic [RAM_AW-1:0] ram_off
);
  localparam int    TAG_W    = ADDR_W - WIN_AW;
  localparam addr_t WIN_V    = WIN_BASE[ADDR_W-1:0];
  localparam int    SPAN_END = WIN_BASE + POSITIONS * (1 << WIN_AW);

  logic [TAG_W-1:0] tag_sel;
  logic             in_win;
  logic             ram_zone;

  assign tag_sel  = WIN_V[ADDR_W-1:WIN_AW] + TAG_W'(sw);
  assign in_win   = (addr[ADDR_W-1:WIN_AW] == tag_sel);
  assign ram_zone = &addr[WIN_AW-1:RAM_AW];

  assign rom_cs  = in_win & ~ram_zone & mem_rd;
  assign ram_cs  = in_win &  ram_zone & (mem_rd | mem_wr);
  assign rom_off = rom_cs ? addr[WIN_AW-1:0] : '0;
  assign ram_off = ram_cs ? addr[RAM_AW-1:0] : '0;

  // R7: ROM is never selected for a write-only cycle
  a_r7_rom_read_only: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> mem_rd);
  // R7: offsets are quiet when deselected
  a_r7_off_idle: assert property (@(posedge clk) disable iff (rst)
    (!rom_cs |-> (rom_off == '0)) and (!ram_cs |-> (ram_off == '0)));
  // R6: RAM never reaches below its top slice of the window
  a_r6_ram_top_zone: assert property (@(posedge clk) disable iff (rst)
    ram_cs |-> (addr[WIN_AW-1:RAM_AW] == '1));
  // R8: memory selects stay inside the selectable span
  a_r8_window_span: assert property (@(posedge clk) disable iff (rst)
    (rom_cs || ram_cs) |-> ((int'(addr) >= WIN_BASE) && (int'(addr) < SPAN_END)));
endmodule

// File: rtl/xcd_top.sv
`timescale 1ns/1ps
module xcd_top
  import xcd_pkg::*;
#(
  parameter int IO_LO_BASE = 'h220,
  parameter int IO_HI_BASE = 'h300,
  parameter int IO_STEP    = 'h10,
  parameter int WIN_BASE   = 'hC0000,
  parameter int RAM_AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [19:0]       bus_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [3:0]        io_base_sw,
  input  logic [3:0]        mem_win_sw,
  output logic              drv_cs,
  output logic [3:0]        drv_idx,
  output logic              rom_cs,
  output logic [12:0]       rom_off,
  output logic              ram_cs,
  output logic [RAM_AW-1:0] ram_off
);
  sw_t io_sw_q, mem_sw_q;

  xcd_sw_latch u_sw (
    .clk       (clk),
    .rst       (rst),
    .io_sw_in  (io_base_sw),
    .mem_sw_in (mem_win_sw),
    .io_sw_q   (io_sw_q),
    .mem_sw_q  (mem_sw_q)
  );

  xcd_io_decode #(
    .IO_LO_BASE (IO_LO_BASE),
    .IO_HI_BASE (IO_HI_BASE),
    .IO_STEP    (IO_STEP)
  ) u_io (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .sw      (io_sw_q),
    .drv_cs  (drv_cs),
    .drv_idx (drv_idx)
  );

  xcd_mem_decode #(
    .WIN_BASE (WIN_BASE),
    .RAM_AW   (RAM_AW)
  ) u_mem (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .sw      (mem_sw_q),
    .rom_cs  (rom_cs),
    .rom_off (rom_off),
    .ram_cs  (ram_cs),
    .ram_off (ram_off)
  );

  // R9: the three targets are mutually exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({drv_cs, rom_cs, ram_cs}));
endmodule

// File: tb/xcd_top_tb.sv
`timescale 1ns/1ps
module xcd_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr = '0;
  logic        mem_rd = 0, mem_wr = 0, io_rd = 0, io_wr = 0;
  logic [3:0]  io_sw = '0, mem_sw = '0;

  logic        drv_cs, rom_cs, ram_cs;
  logic [3:0]  drv_idx;
  logic [12:0] rom_off;
  logic [9:0]  ram_off;
  logic        drv_cs_h, rom_cs_h, ram_cs_h;
  logic [3:0]  drv_idx_h;
  logic [12:0] rom_off_h;
  logic [8:0]  ram_off_h;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  xcd_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .io_base_sw(io_sw), .mem_win_sw(mem_sw),
    .drv_cs(drv_cs), .drv_idx(drv_idx), .rom_cs(rom_cs), .rom_off(rom_off),
    .ram_cs(ram_cs), .ram_off(ram_off)
  );

  xcd_top #(.RAM_AW(9)) u_dut_half (
    .clk(clk), .rst(rst), .bus_addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .io_base_sw(io_sw), .mem_win_sw(mem_sw),
    .drv_cs(drv_cs_h), .drv_idx(drv_idx_h), .rom_cs(rom_cs_h), .rom_off(rom_off_h),
    .ram_cs(ram_cs_h), .ram_off(ram_off_h)
  );

  // stimulus fields: io_sw, mem_sw, addr, {io_rd,io_wr,mem_rd,mem_wr}
  // expected fields: drv_cs, drv_idx, rom_cs, ram_cs
  localparam int VW = 39;
  localparam logic [VW-1:0] VEC [8] = '{
    {4'h0, 4'h0, 20'h00221, 4'b1000, 1'b1, 4'h8, 1'b0, 1'b0},
    {4'h8, 4'h0, 20'h00308, 4'b0100, 1'b1, 4'h1, 1'b0, 1'b0},
    {4'hF, 4'h0, 20'h00376, 4'b1000, 1'b1, 4'h6, 1'b0, 1'b0},
    {4'h0, 4'h5, 20'hCA010, 4'b0010, 1'b0, 4'h0, 1'b1, 1'b0},
    {4'h0, 4'h5, 20'hCBC00, 4'b0010, 1'b0, 4'h0, 1'b0, 1'b1},
    {4'h0, 4'h5, 20'hCBC00, 4'b1000, 1'b0, 4'h0, 1'b0, 1'b0},
    {4'h2, 4'h0, 20'h00240, 4'b0001, 1'b0, 4'h0, 1'b0, 1'b0},
    {4'h0, 4'hF, 20'hDFFFF, 4'b0001, 1'b0, 4'h0, 1'b0, 1'b1}
  };

  function automatic logic [19:0] io_base(input logic [3:0] s);
    return s[3] ? 20'h300 + 20'(s[2:0]) * 20'h10 : 20'h220 + 20'(s[2:0]) * 20'h10;
  endfunction

  function automatic logic [19:0] win_base(input logic [3:0] s);
    return 20'hC0000 + 20'(s) * 20'h2000;
  endfunction

  function automatic logic [3:0] exp_idx(input logic [3:0] o);
    return {o[0], o[2], o[1], o[3]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] isw, input logic [3:0] msw);
    @(negedge clk);
    {io_rd, io_wr, mem_rd, mem_wr} = '0;
    rst = 1'b1;
    io_sw = isw;
    mem_sw = msw;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input logic [19:0] a, input logic [3:0] strb);
    @(negedge clk);
    addr = a;
    {io_rd, io_wr, mem_rd, mem_wr} = strb;
    #3;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // reset state: no strobes, nothing selected
    do_reset(4'h0, 4'h0);
    drive(20'h00220, 4'b0000);
    check(!drv_cs && !rom_cs && !ram_cs && drv_idx == 0, "R8 idle after reset",
          {drv_cs, rom_cs, ram_cs}, 0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      do_reset(e[38:35], e[34:31]);
      drive(e[30:11], e[10:7]);
      check(drv_cs == e[6] && drv_idx == e[5:2] && rom_cs == e[1] && ram_cs == e[0],
            "R2 R4 R6 R7 R8 table", {drv_cs, drv_idx, rom_cs, ram_cs}, int'(e[6:0]));
    end

    // port block sweep
    for (int s = 0; s < 16; s++) begin
      logic [19:0] b;
      b = io_base(4'(s));
      do_reset(4'(s), 4'h0);
      for (int k = 0; k < 4; k++) begin
        logic [3:0] o;
        o = (k == 0) ? 4'h0 : (k == 1) ? 4'h1 : (k == 2) ? 4'h8 : 4'hF;
        drive(b + 20'(o), (k[0]) ? 4'b0100 : 4'b1000);
        check(drv_cs && drv_idx == exp_idx(o), "R2 R4 port hit", {drv_cs, drv_idx},
              {1'b1, exp_idx(o)});
        drive(b + 20'(o), 4'b0011);
        check(!drv_cs && drv_idx == 0, "R3 memory strobe at port", {drv_cs, drv_idx}, 0);
      end
      drive(b - 20'h1, 4'b0100);
      check(!drv_cs, "R8 port below block", drv_cs, 0);
      drive(b + 20'h10, 4'b1000);
      check(!drv_cs, "R8 port above block", drv_cs, 0);
    end

    // window sweep, both RAM sizes
    for (int s = 0; s < 16; s++) begin
      logic [19:0] w;
      w = win_base(4'(s));
      do_reset(4'h0, 4'(s));
      drive(w + 20'h0123, 4'b0010);
      check(rom_cs && !ram_cs && rom_off == 13'h0123, "R5 R7 rom read", rom_off, 'h123);
      drive(w + 20'h0123, 4'b0001);
      check(!rom_cs && !ram_cs && rom_off == 0, "R7 rom write ignored", {rom_cs, ram_cs}, 0);
      drive(w + 20'h1FFF, 4'b0001);
      check(ram_cs && ram_off == 10'h3FF && ram_cs_h && ram_off_h == 9'h1FF,
            "R6 ram top write", {ram_cs, ram_off}, {1'b1, 10'h3FF});
      drive(w + 20'h1D00, 4'b0010);
      check(ram_cs && ram_off == 10'h100 && rom_cs_h && !ram_cs_h && rom_off_h == 13'h1D00,
            "R6 R7 boundary per size", {ram_cs, rom_cs_h}, 3);
      drive(w + 20'h1BFF, 4'b0010);
      check(rom_cs && rom_off == 13'h1BFF && !ram_cs, "R6 last rom byte", rom_off, 'h1BFF);
      drive(w - 20'h1, 4'b0010);
      check(!rom_cs && !ram_cs, "R8 below window", {rom_cs, ram_cs}, 0);
      drive(w + 20'h2000, 4'b0010);
      check(!rom_cs && !ram_cs, "R8 above window", {rom_cs, ram_cs}, 0);
      drive(w + 20'h0010, 4'b1100);
      check(!rom_cs && !ram_cs && !drv_cs, "R8 io strobe in window",
            {drv_cs, rom_cs, ram_cs}, 0);
      drive(w + 20'h1FFF, 4'b0011);
      check(({drv_cs, rom_cs, ram_cs} == 3'b001), "R9 single select",
            {drv_cs, rom_cs, ram_cs}, 1);
    end

    // R1: switch changes after release are ignored
    do_reset(4'h3, 4'h2);
    io_sw = 4'h9;
    mem_sw = 4'hA;
    repeat (3) @(posedge clk);
    drive(io_base(4'h3) + 20'h2, 4'b1000);
    check(drv_cs && drv_idx == 4'h2, "R1 old port kept", {drv_cs, drv_idx}, 'h12);
    drive(io_base(4'h9) + 20'h2, 4'b1000);
    check(!drv_cs, "R1 new port ignored", drv_cs, 0);
    drive(win_base(4'h2) + 20'h4, 4'b0010);
    check(rom_cs && rom_off == 13'h4, "R1 old window kept", rom_cs, 1);
    drive(win_base(4'hA) + 20'h4, 4'b0010);
    check(!rom_cs, "R1 new window ignored", rom_cs, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule